// File: doc/BRIEF.md
# Accumulator ALU with Sign/Zero Condition Register

This block is the arithmetic and logic stage of a small accumulator-style processor. It takes a register operand, a memory operand and an operation code, and returns a 16-bit result together with an enable that tells the register file whether to write that result back. The result path is purely combinational and is valid in the same cycle as the input strobe.

Next to the datapath sits a two-bit condition register. On each clock edge where a valid operation of a flag-setting class is presented, the register takes a new value. The new value comes either from the sign and zero state of the 16-bit result or, for signed compare, from the true signed relation of the two operands. The register encodes a positive, zero or negative outcome as 00, 01 or 10. Load, store, idle cycles and unassigned codes leave it untouched.

Data words number their bits from the left: bit 0 is the most significant bit and bit 15 the least. The sign of a word is therefore bit 0.

Top module: `alu_core`

## Requirements
- R1: The condition register output `flags[0]` is the sign indicator and `flags[1]` the zero indicator. A greater-than-zero outcome reads 00, equal reads 01 and less-than reads 10, and 11 never appears. For result-driven updates the sign is data bit 0, the leftmost and most significant bit.
- R2: Opcode 0 (add) returns register + memory modulo 2^16 with write-back, and the flags describe the wrapped result.
- R3: Opcode 1 (subtract) returns register - memory modulo 2^16 with write-back, and the flags describe the wrapped result.
- R4: Opcodes 2, 3 and 4 return the bitwise AND, OR and XOR of the two operands with write-back, and the flags describe the result.
- R5: Opcode 5 (compare) never asserts write-back. It sets the flags from the signed two's-complement relation of register versus memory operand, so wrap in the difference cannot invert the outcome.
- R6: Opcode 6 (address pass-through) returns the memory operand, which carries the effective address, with write-back, and the flags describe that value.
- R7: Opcode 7 (load) returns the memory operand with write-back. Opcode 8 (store) returns the register operand without write-back. Neither changes the flags.
- R8: While `in_valid` is low, `wb_en` is low and the flags hold their value.
- R9: A synchronous active-high reset sets the flags to 00.
- R10: Opcodes 9 to 15 are unassigned: no write-back and no flag change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation code |
| reg_opnd | input | 16 | Register operand, bit 0 is the MSB |
| mem_opnd | input | 16 | Memory operand or effective address, bit 0 is the MSB |
| result | output | 16 | Combinational result, bit 0 is the MSB |
| wb_en | output | 1 | Register write-back enable |
| flags | output | 2 | Condition register: sign, zero |

## Verification
The assertions assume that `op`, `reg_opnd` and `mem_opnd` are known whenever `in_valid` is high, and that inputs change only away from the rising edge, so the sampled operands are the ones the flags were computed from. The stimulus drives every input on the falling edge, holds it through the next rising edge and drops the strobe afterwards. It also asserts reset at the first edge, so no flag check sees a value from before reset. The compare vectors include operand pairs whose difference wraps, so the signed-relation property is exercised where a difference-based design would disagree.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_CMP = 4'd5,
        OP_LEA = 4'd6,
        OP_LD  = 4'd7,
        OP_ST  = 4'd8
    } alu_op_e;

    // sign sits in the upper bit so {sign, zero} reads 00 / 01 / 10
    typedef struct packed {
        logic sign;
        logic zero;
    } cond_t;

    typedef struct packed {
        logic wr;     // result goes back to the register
        logic setf;   // condition register updates
        logic rel;    // flags come from operand relation, not result
    } op_ctl_t;

    function automatic op_ctl_t decode_op(logic [OP_W-1:0] code);
        op_ctl_t c;
        c = '0;
        case (code)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: begin
                c.wr   = 1'b1;
                c.setf = 1'b1;
            end
            OP_CMP: begin
                c.setf = 1'b1;
                c.rel  = 1'b1;
            end
            OP_LEA: begin
                c.wr   = 1'b1;
                c.setf = 1'b1;
            end
            OP_LD:   c.wr = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_datapath.sv
`timescale 1ns/1ps
module alu_datapath
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [OP_W-1:0]   op,
    input  logic [0:DATA_W-1] a,
    input  logic [0:DATA_W-1] b,
    output logic [0:DATA_W-1] res,
    output logic              rel_lt,
    output logic              rel_eq
);

    always_comb begin
        case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_LEA:  res = b;
            OP_LD:   res = b;
            OP_ST:   res = a;
            default: res = '0;
        endcase
    end

    // signed relation taken directly, immune to difference wrap
    assign rel_lt = $signed(a) < $signed(b);
    assign rel_eq = (a == b);

endmodule

// File: rtl/alu_flag_gen.sv
`timescale 1ns/1ps
module alu_flag_gen
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              use_rel,
    input  logic [0:DATA_W-1] res,
    input  logic              rel_lt,
    input  logic              rel_eq,
    output cond_t             nxt
);

    cond_t from_res;
    cond_t from_rel;

    assign from_res.sign = res[0];
    assign from_res.zero = (res == '0);
    assign from_rel.sign = rel_lt;
    assign from_rel.zero = rel_eq;

    assign nxt = use_rel ? from_rel : from_res;

endmodule

// File: rtl/alu_status_reg.sv
`timescale 1ns/1ps
module alu_status_reg
    import alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  upd,
    input  cond_t nxt,
    output cond_t q
);

    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (upd) q <= nxt;
    end

    // R9
    reset_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));

    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        !(q.sign && q.zero));

endmodule

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [0:DATA_W-1] reg_opnd,
    input  logic [0:DATA_W-1] mem_opnd,
    output logic [0:DATA_W-1] result,
    output logic              wb_en,
    output logic [0:1]        flags
);

    op_ctl_t ctl;
    logic    lt;
    logic    eq;
    cond_t   nxt;
    cond_t   cur;

    assign ctl = decode_op(op);

    alu_datapath #(.DATA_W(DATA_W)) u_dp (
        .op     (op),
        .a      (reg_opnd),
        .b      (mem_opnd),
        .res    (result),
        .rel_lt (lt),
        .rel_eq (eq)
    );

    alu_flag_gen #(.DATA_W(DATA_W)) u_fg (
        .use_rel (ctl.rel),
        .res     (result),
        .rel_lt  (lt),
        .rel_eq  (eq),
        .nxt     (nxt)
    );

    alu_status_reg u_sr (
        .clk (clk),
        .rst (rst),
        .upd (in_valid & ctl.setf),
        .nxt (nxt),
        .q   (cur)
    );

    assign wb_en = in_valid & ctl.wr;
    assign flags = {cur.sign, cur.zero};

    // R5
    cmp_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_CMP) |-> !wb_en);

    // R5
    cmp_rel_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_CMP) |=>
        (flags == (($signed($past(reg_opnd)) < $signed($past(mem_opnd))) ? 2'b10 :
                   (($past(reg_opnd) == $past(mem_opnd)) ? 2'b01 : 2'b00))));

    // R2
    res_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op <= OP_XOR || op == OP_LEA)) |=>
        (flags == {$past(result[0]), ($past(result) == '0)}));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || op >= OP_LD) |=> $stable(flags));

    // R10
    unknown_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (op > OP_ST) |-> !wb_en);

endmodule

// File: tb/tb_alu_core.sv
`timescale 1ns/1ps
module tb_alu_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [15:0] reg_opnd = '0;
    logic [15:0] mem_opnd = '0;
    logic [15:0] result;
    logic        wb_en;
    logic [1:0]  flags;

    int checks = 0;
    int errors = 0;
    logic [1:0] mflags = 2'b00;
    bit done = 0;
    int cyc = 0;

    alu_core dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .reg_opnd(reg_opnd), .mem_opnd(mem_opnd),
        .result(result), .wb_en(wb_en), .flags(flags)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // presents one operation and checks result, write-back and next flags
    task automatic apply(input logic [3:0] o, input logic [15:0] a, input logic [15:0] b,
                         input bit v, input string tag);
        logic [15:0] r;
        bit wr, sf, rchk;
        logic [1:0] nf;
        r = '0; wr = 0; sf = 0; rchk = 1;
        case (o)
            4'd0: begin r = a + b; wr = 1; sf = 1; end
            4'd1: begin r = a - b; wr = 1; sf = 1; end
            4'd2: begin r = a & b; wr = 1; sf = 1; end
            4'd3: begin r = a | b; wr = 1; sf = 1; end
            4'd4: begin r = a ^ b; wr = 1; sf = 1; end
            4'd5: begin sf = 1; rchk = 0; end
            4'd6: begin r = b; wr = 1; sf = 1; end
            4'd7: begin r = b; wr = 1; end
            4'd8: begin r = a; end
            default: rchk = 0;
        endcase
        if (o == 4'd5)
            nf = ($signed(a) < $signed(b)) ? 2'b10 : ((a == b) ? 2'b01 : 2'b00);
        else
            nf = {r[15], (r == 16'h0)};
        if (!v) begin wr = 0; sf = 0; rchk = 0; end
        @(negedge clk);
        in_valid = v; op = o; reg_opnd = a; mem_opnd = b;
        #1;
        if (rchk) chk(result == r, {tag, " result"}, 32'(result), 32'(r));
        chk(wb_en == wr, {tag, " wb_en"}, 32'(wb_en), 32'(wr));
        if (sf) mflags = nf;
        @(negedge clk);
        chk(flags == mflags, {tag, " flags"}, 32'(flags), 32'(mflags));
        in_valid = 0;
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        mflags = 2'b00;
        chk(flags == 2'b00, "R9 reset state", 32'(flags), 0);
    endtask

    task automatic t_add();
        apply(4'd0, 16'h0003, 16'h0004, 1, "R2 add");
        apply(4'd0, 16'hFFFF, 16'h0001, 1, "R2 add wrap zero");
        apply(4'd0, 16'h7FFF, 16'h0001, 1, "R1 sign from MSB");
    endtask

    task automatic t_sub();
        apply(4'd1, 16'h0005, 16'h0005, 1, "R3 sub zero");
        apply(4'd1, 16'h0002, 16'h0005, 1, "R3 sub negative");
        apply(4'd1, 16'h8000, 16'h0001, 1, "R3 sub wrap positive");
    endtask

    task automatic t_logic();
        apply(4'd2, 16'hF0F0, 16'h0F0F, 1, "R4 and");
        apply(4'd3, 16'h8000, 16'h0001, 1, "R4 or");
        apply(4'd4, 16'h1234, 16'h1230, 1, "R4 xor");
    endtask

    task automatic t_cmp();
        apply(4'd5, 16'h0005, 16'h0003, 1, "R5 cmp greater");
        apply(4'd5, 16'h0003, 16'h0003, 1, "R5 cmp equal");
        apply(4'd5, 16'hFFFF, 16'h0001, 1, "R5 cmp less");
        apply(4'd5, 16'h7FFF, 16'h8000, 1, "R5 cmp overflow greater");
        apply(4'd5, 16'h8000, 16'h7FFF, 1, "R5 cmp overflow less");
    endtask

    task automatic t_lea();
        apply(4'd6, 16'h1111, 16'h0000, 1, "R6 lea zero");
        apply(4'd6, 16'h0000, 16'h9000, 1, "R6 lea negative");
    endtask

    task automatic t_ld_st();
        apply(4'd7, 16'h0005, 16'h0000, 1, "R7 load");
        apply(4'd8, 16'h0000, 16'h0042, 1, "R7 store");
    endtask

    task automatic t_idle();
        apply(4'd6, 16'h0000, 16'h0001, 1, "R6 lea positive");
        apply(4'd0, 16'h0000, 16'h0000, 0, "R8 idle");
    endtask

    task automatic t_unknown();
        apply(4'd12, 16'h0000, 16'h0000, 1, "R10 code 12");
        apply(4'd15, 16'h8000, 16'h0000, 1, "R10 code 15");
    endtask

    task automatic t_reset_mid();
        apply(4'd6, 16'h0000, 16'h8000, 1, "R1 negative before reset");
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        mflags = 2'b00;
        chk(flags == 2'b00, "R9 reset clears flags", 32'(flags), 0);
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_cmp();
        t_lea();
        t_ld_st();
        t_idle();
        t_unknown();
        t_reset_mid();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule